// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block forms the six syndromes of a received RS(255,249) codeword whose symbols are elements of GF(2^8). Symbols arrive one per accepted cycle on an 8-bit input, qualified by a valid flag. A last flag marks the final symbol, and the highest-degree coefficient comes first. One Horner accumulator per generator root runs in parallel. Each accumulator multiplies its running value by a fixed power of alpha and adds the new symbol. The first symbol of a codeword loads the accumulator directly, so nothing is carried over from the previous codeword.

When the last symbol is accepted, the six evaluations are registered onto a flat output bus together with a one-cycle done strobe and an error-present flag. Shortened codewords need no padding. Leading zero symbols add nothing to a Horner evaluation, so a shorter stream gives the same result as a full-length one with its omitted zero symbols. Codewords may follow one another with no idle cycle between them. The block feeds a downstream locator and magnitude solver, which can correct up to three symbol errors.

Top module: `rs_syndrome_calc`

## Requirements
- R1: While reset is asserted (rst_n low), syn_out is all zero, syn_done is 0 and syn_nonzero is 0.
- R2: An error-free codeword yields all-zero syndromes and syn_nonzero = 0. A codeword is error-free when it is divisible by the product of (x + alpha^j) for j = 0..5, in the field built on polynomial 0x11D with alpha = 0x02.
- R3: syn_out[8*j +: 8] equals the XOR over i of r_i * alpha^(j*(L-1-i)), for j = 0..5. Here r_i is the i-th accepted symbol of a codeword of length L, so the first symbol is the coefficient of x^(L-1).
- R4: syn_done is high for exactly the one cycle after the clock edge that accepts a symbol with in_last = 1, and is low at all other times.
- R5: syn_nonzero is 1 exactly when at least one bit of syn_out is 1. It updates together with syn_out.
- R6: syn_out and syn_nonzero hold their values in every cycle in which syn_done is low.
- R7: In cycles with in_valid = 0, in_sym and in_last are ignored and the accumulators keep their state.
- R8: Codewords of any length from 1 to 255 symbols are accepted without padding. A shortened codeword gives the same syndromes as the full-length codeword with its leading zero symbols.
- R9: A new codeword may begin in the cycle right after the last symbol of the previous one. Its first symbol starts a fresh evaluation.
- R10: A one-symbol codeword with value v yields v in all six syndrome fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol on in_sym is accepted this cycle |
| in_sym | input | 8 | Received symbol, highest degree first |
| in_last | input | 1 | Accepted symbol is the final one of the codeword |
| syn_out | output | 48 | Six syndromes; field j holds the evaluation at alpha^j |
| syn_done | output | 1 | One-cycle strobe: new syndromes present |
| syn_nonzero | output | 1 | Some syndrome is nonzero (errors detected) |

## Verification
The assertions assume that in_last is only meaningful together with in_valid. They also assume that each codeword ends with a last flag before the stream stops being checked. The stimulus always closes a codeword with an accepted last symbol. It drives random values on in_sym and sets in_last to 1 during idle cycles, so that the ignore rule is actually tested. Random lengths from the minimum codeword up to 255 exercise shortening. Consecutive codewords are sent with no gap, and one-symbol codewords are included so that done strobes can occur on adjacent cycles.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int SYM_W      = 8;
  localparam int FIELD_POLY = 'h11D;

  typedef logic [SYM_W-1:0] sym_t;

  // multiply a field element by alpha (x), reducing by the field polynomial
  function automatic sym_t gf_xtime(input sym_t a);
    logic [SYM_W:0] t;
    t = {a, 1'b0};
    if (t[SYM_W]) t = t ^ FIELD_POLY[SYM_W:0];
    return t[SYM_W-1:0];
  endfunction

  // general GF(2^SYM_W) product, shift-and-add from the top bit of b
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t p;
    p = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      p = gf_xtime(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  // alpha raised to a small non-negative exponent
  function automatic sym_t gf_alpha_pow(input int e);
    sym_t p;
    p = sym_t'(1);
    for (int i = 0; i < 256; i++) begin
      if (i < e) p = gf_xtime(p);
    end
    return p;
  endfunction

  // one Horner step: acc * root + sym, or a plain load on a fresh codeword
  function automatic sym_t horner_step(input sym_t acc, input sym_t root,
                                       input sym_t sym, input logic fresh);
    if (fresh) return sym;
    return gf_mul(acc, root) ^ sym;
  endfunction

endpackage

// File: rtl/rs_syn_frame_ctrl.sv
module rs_syn_frame_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic first_sym,
  output logic sym_accept,
  output logic word_end
);

  logic in_word_q;

  assign sym_accept = in_valid;
  assign first_sym  = in_valid && !in_word_q;
  assign word_end   = in_valid && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        in_word_q <= 1'b0;
    else if (word_end) in_word_q <= 1'b0;
    else if (in_valid) in_word_q <= 1'b1;
  end

endmodule

// File: rtl/rs_syn_horner_cell.sv
module rs_syn_horner_cell
  import rs_syn_pkg::*;
#(
  parameter int ROOT_EXP = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_accept,
  input  logic first_sym,
  input  sym_t sym,
  output sym_t acc_next
);

  localparam sym_t ROOT = gf_alpha_pow(ROOT_EXP);

  sym_t acc_q;

  assign acc_next = horner_step(acc_q, ROOT, sym, first_sym);

  always_ff @(posedge clk) begin
    if (!rst_n)          acc_q <= '0;
    else if (sym_accept) acc_q <= acc_next;
  end

endmodule

// File: rtl/rs_syn_out_reg.sv
module rs_syn_out_reg
  import rs_syn_pkg::*;
#(
  parameter int NUM_SYN = 6,
  localparam int BUS_W  = NUM_SYN * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_end,
  input  logic [BUS_W-1:0] syn_next,
  output logic [BUS_W-1:0] syn_out,
  output logic             syn_done,
  output logic             syn_nonzero
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syn_out     <= '0;
      syn_done    <= 1'b0;
      syn_nonzero <= 1'b0;
    end else begin
      syn_done <= word_end;
      if (word_end) begin
        syn_out     <= syn_next;
        syn_nonzero <= |syn_next;
      end
    end
  end

endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
  import rs_syn_pkg::*;
#(
  parameter int NUM_SYN    = 6,
  parameter int FIRST_ROOT = 0,
  localparam int BUS_W     = NUM_SYN * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             in_last,
  output logic [BUS_W-1:0] syn_out,
  output logic             syn_done,
  output logic             syn_nonzero
);

  logic             first_sym;
  logic             sym_accept;
  logic             word_end;
  logic [BUS_W-1:0] syn_next;

  rs_syn_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .first_sym  (first_sym),
    .sym_accept (sym_accept),
    .word_end   (word_end)
  );

  for (genvar j = 0; j < NUM_SYN; j++) begin : g_root
    rs_syn_horner_cell #(.ROOT_EXP(FIRST_ROOT + j)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .sym_accept (sym_accept),
      .first_sym  (first_sym),
      .sym        (in_sym),
      .acc_next   (syn_next[j*SYM_W +: SYM_W])
    );
  end

  rs_syn_out_reg #(.NUM_SYN(NUM_SYN)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_end    (word_end),
    .syn_next    (syn_next),
    .syn_out     (syn_out),
    .syn_done    (syn_done),
    .syn_nonzero (syn_nonzero)
  );

endmodule

// File: rtl/rs_syn_checker.sv
module rs_syn_checker #(
  parameter int NUM_SYN = 6,
  parameter int SYM_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SYM_W-1:0]         in_sym,
  input logic                     first_sym,
  input logic                     word_end,
  input logic [NUM_SYN*SYM_W-1:0] syn_out,
  input logic                     syn_done,
  input logic                     syn_nonzero
);

  a_r4_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> syn_done);

  a_r4_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !word_end |=> !syn_done);

  a_r6_hold_between_done: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_done |-> ($stable(syn_out) && $stable(syn_nonzero)));

  a_r5_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    syn_nonzero == (syn_out != '0));

  a_r10_single_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && first_sym) |=> (syn_out == {NUM_SYN{$past(in_sym)}}));

endmodule

bind rs_syndrome_calc rs_syn_checker #(.NUM_SYN(NUM_SYN), .SYM_W(rs_syn_pkg::SYM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_sym      (in_sym),
  .first_sym   (first_sym),
  .word_end    (word_end),
  .syn_out     (syn_out),
  .syn_done    (syn_done),
  .syn_nonzero (syn_nonzero)
);

// File: tb/rs_syndrome_calc_tb_top.sv
module rs_syndrome_calc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NS         = 6;
  localparam int QD         = 256;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_sym;
  logic          in_last;
  logic [47:0]   syn_out;
  logic          syn_done;
  logic          syn_nonzero;

  rs_syndrome_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .in_last(in_last), .syn_out(syn_out), .syn_done(syn_done),
    .syn_nonzero(syn_nonzero)
  );

  int checks = 0;
  int failures = 0;

  // log / antilog tables for the bench's own field arithmetic
  int alog [0:511];
  int lg   [0:255];
  int gen  [0:6];
  int cw   [0:254];

  logic [47:0] expq [0:QD-1];
  string       tagq [0:QD-1];
  int wr_i = 0, rd_i = 0, words_sent = 0, dones_seen = 0;

  function automatic int fmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return alog[lg[a] + lg[b]];
  endfunction

  function automatic logic [47:0] ref_syn(input int len);
    logic [47:0] s;
    s = '0;
    for (int j = 0; j < NS; j++) begin
      int acc;
      acc = 0;
      for (int i = 0; i < len; i++)
        acc = acc ^ fmul(cw[i], alog[(j * (len - 1 - i)) % 255]);
      s[j*8 +: 8] = acc[7:0];
    end
    return s;
  endfunction

  task automatic fail_msg(input string req, input logic [47:0] act, input logic [47:0] exp);
    failures++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic build_tables();
    int x;
    x = 1;
    for (int i = 0; i < 255; i++) begin
      alog[i] = x; alog[i+255] = x; lg[x] = i;
      x = x << 1;
      if ((x & 256) != 0) x = x ^ 'h11D;
    end
    alog[510] = alog[0]; alog[511] = alog[1]; lg[0] = 0;
    for (int i = 0; i <= 6; i++) gen[i] = 0;
    gen[0] = 1;
    for (int r = 0; r < NS; r++) begin
      for (int i = 6; i >= 1; i--) gen[i] = gen[i-1] ^ fmul(gen[i], alog[r]);
      gen[0] = fmul(gen[0], alog[r]);
    end
  endtask

  // systematic encoding of len-6 random data symbols into cw[0:len-1]
  task automatic build_clean(input int len);
    int p [0:5];
    int fb;
    for (int k = 0; k < 6; k++) p[k] = 0;
    for (int i = 0; i < len - 6; i++) begin
      cw[i] = $urandom % 256;
      fb = cw[i] ^ p[5];
      for (int k = 5; k >= 1; k--) p[k] = p[k-1] ^ fmul(fb, gen[k]);
      p[0] = fmul(fb, gen[0]);
    end
    for (int k = 0; k < 6; k++) cw[len - 6 + k] = p[5 - k];
  endtask

  task automatic inject(input int len, input int nerr);
    int pos [0:2];
    for (int e = 0; e < nerr; e++) begin
      bit dup;
      do begin
        pos[e] = $urandom % len;
        dup = 1'b0;
        for (int q = 0; q < e; q++) if (pos[q] == pos[e]) dup = 1'b1;
      end while (dup);
      cw[pos[e]] = cw[pos[e]] ^ (1 + ($urandom % 255));
    end
  endtask

  task automatic push_exp(input logic [47:0] e, input string tag);
    expq[wr_i % QD] = e; tagq[wr_i % QD] = tag; wr_i++;
  endtask

  // R7: idle cycles carry junk on in_sym with in_last set
  task automatic send_word(input int len, input bit gaps);
    words_sent++;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b1; in_sym = 8'($urandom);
      end
      @(posedge clk); #1;
      in_valid = 1'b1; in_sym = 8'(cw[i]); in_last = (i == len - 1);
    end
  endtask

  task automatic go_idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_sym = 8'h00;
  endtask

  // R4 timing reference: an accepted last symbol at the previous edge
  logic acc_last_q = 1'b0;
  always @(posedge clk) acc_last_q <= rst_n && in_valid && in_last;

  logic [47:0] held = '0;
  logic        held_nz = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (syn_done !== acc_last_q) begin
        checks++;
        fail_msg("R4 done timing", {47'd0, syn_done}, {47'd0, acc_last_q});
      end
      if (syn_done) begin
        dones_seen++;
        checks++;
        if (rd_i >= wr_i) fail_msg("R4 unexpected done", syn_out, '0);
        else begin
          if (syn_out !== expq[rd_i % QD]) fail_msg(tagq[rd_i % QD], syn_out, expq[rd_i % QD]);
          checks++;
          if (syn_nonzero !== (expq[rd_i % QD] != '0))
            fail_msg("R5 nonzero flag", {47'd0, syn_nonzero}, {47'd0, expq[rd_i % QD] != '0});
          rd_i++;
        end
        held = syn_out; held_nz = syn_nonzero;
      end else if (syn_out !== held || syn_nonzero !== held_nz) begin
        checks++;
        fail_msg("R6 hold", syn_out, held);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    build_tables();
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_sym = 8'h00;
    repeat (3) @(posedge clk);
    // R1: reset state, with junk on the inputs
    #1; in_valid = 1'b1; in_sym = 8'hA5; in_last = 1'b1;
    @(negedge clk);
    checks++;
    if (syn_out !== '0 || syn_done !== 1'b0 || syn_nonzero !== 1'b0)
      fail_msg("R1 reset state", {syn_out[45:0], syn_done, syn_nonzero}, '0);
    @(posedge clk); #1; in_valid = 1'b0; in_last = 1'b0;
    rst_n = 1'b1;

    // R2: full-length clean codeword; the reference must agree it is zero
    build_clean(255);
    checks++;
    if (ref_syn(255) != '0) fail_msg("R2 bench encoder", ref_syn(255), '0);
    push_exp('0, "R2 clean full length");
    send_word(255, 1'b0);

    // R10 / R9: one-symbol codewords back to back
    cw[0] = 'h00; push_exp({6{8'h00}}, "R10 single 00"); send_word(1, 1'b0);
    cw[0] = 'h5A; push_exp({6{8'h5A}}, "R10 single 5A"); send_word(1, 1'b0);
    cw[0] = 'hFF; push_exp({6{8'hFF}}, "R10 single FF"); send_word(1, 1'b0);

    // R8: shortest clean codeword, then the same with an error (R3)
    build_clean(7); push_exp('0, "R8 shortened clean len7"); send_word(7, 1'b0);
    build_clean(7); inject(7, 1); push_exp(ref_syn(7), "R3 len7 one error"); send_word(7, 1'b0);

    // R9: after the single error word, a clean word must restart cleanly
    build_clean(40); push_exp('0, "R9 fresh start after error"); send_word(40, 1'b0);

    // random mix: R3 R7 R8 R9
    for (int w = 0; w < 40; w++) begin
      int len, nerr;
      bit gaps;
      len  = 7 + ($urandom % 249);
      nerr = $urandom % 4;
      gaps = ($urandom % 2) == 1;
      build_clean(len);
      if (nerr != 0) inject(len, nerr);
      if (nerr == 0) push_exp('0, gaps ? "R7 R8 clean with gaps" : "R8 R9 clean");
      else push_exp(ref_syn(len), gaps ? "R3 R7 errors with gaps" : "R3 R9 errors");
      send_word(len, gaps);
    end

    go_idle();
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dones_seen != words_sent)
      fail_msg("R4 done count", 48'(dones_seen), 48'(words_sent));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule